// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block runs the descriptor side of one DMA channel. Software gives it the address of a first descriptor and a start pulse. The block then reads that descriptor over a plain 32-bit memory read port. Each descriptor is a fixed record of eight words. The words are captured one-for-one into the channel's working registers, and each register keeps the bit layout of the word that loads it.

With the descriptor loaded, the block hands a transfer request to a separate data mover and waits for that mover's done strobe. The request carries a 64-bit source, a 64-bit destination, a byte count and a control word. The block then follows the descriptor's 64-bit link pointer to the next record. It keeps doing this until the chain ends, with no software involvement between transfers.

Each record may carry different addresses, lengths and attributes. A zero byte count skips the transfer. A misaligned descriptor address or a memory read error stops the chain and leaves a sticky error flag set until software clears it.

Top module: `dsc_chain_walker`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `mem_req_o`, `xfer_req_o`, `chain_done_o` and `err_o` are all 0.
- R2: A descriptor is fetched as eight reads at consecutive word addresses base+0, base+4, ... base+28. Each read holds `mem_req_o` and `mem_addr_o` steady until a cycle with `mem_ack_i` high, and the address advances by 4 after each accepted read.
- R3: The words map to fields in fetch order: word 0 source[31:0], word 1 source[63:32], word 2 destination[31:0], word 3 destination[63:32], word 4 link[31:0], word 5 link[63:32], word 6 byte count, word 7 control. Source, destination, count and control appear on the `xfer_*` outputs.
- R4: After the eighth word, a nonzero count raises `xfer_req_o`. It stays high, with all `xfer_*` fields stable, until the cycle in which `xfer_done_i` is seen. Memory reads and transfer requests never overlap.
- R5: After each descriptor the block follows the 64-bit link. A link of zero ends the chain: `busy_o` falls and `chain_done_o` pulses for one cycle.
- R6: A descriptor whose byte count is zero raises no transfer request, and the walk moves straight on to its link.
- R7: A start pulse that arrives while `busy_o` is high is ignored. The running chain continues unchanged.
- R8: A start address or link address with any of its low five bits set (not 32-byte aligned) stops the channel without issuing a read. It sets `err_o` and gives no done pulse.
- R9: A read accepted with `mem_err_i` high stops the chain at once. It sets `err_o`, issues no further reads or transfers, and gives no done pulse.
- R10: `err_o` stays set until a cycle with `err_clr_i` high clears it.
- R11: A start with a first-descriptor address of zero issues no reads and pulses `chain_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start the channel (sampled when idle) |
| head_addr_i | input | 64 | Address of the first descriptor |
| err_clr_i | input | 1 | Clears the sticky error flag |
| busy_o | output | 1 | Channel is walking a chain |
| chain_done_o | output | 1 | One-cycle pulse when a chain ends normally |
| err_o | output | 1 | Sticky error flag |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 64 | Byte address of the requested word |
| mem_ack_i | input | 1 | Read accepted, data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Read error, qualified by `mem_ack_i` |
| xfer_req_o | output | 1 | Transfer request to the data mover |
| xfer_src_o | output | 64 | Transfer source address |
| xfer_dst_o | output | 64 | Transfer destination address |
| xfer_len_o | output | 32 | Transfer byte count |
| xfer_ctl_o | output | 32 | Transfer control word |
| xfer_done_i | input | 1 | Data mover finished the transfer |

## Verification
A wrong word index or base register shows on the very next read. The bench checks every accepted read address against the descriptor base it expects, so the first out-of-place fetch is seen within one cycle of the bad state. A misrouted or stale field register shows at the first transfer handshake, where all four fields are compared. A wrong walk state shows as a missing, extra or out-of-order transfer, a read count other than eight per descriptor, a missing done pulse, or an error flag in the wrong state once the channel returns to idle. The sweeps vary chain length, base ordering, read stalls, mover delay and zero-count placement, so each of these is exercised across many chains.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int unsigned DSC_WORDS = 8;
   localparam int unsigned DSC_IDX_W = $clog2(DSC_WORDS);

   // Word positions inside a descriptor; the fetch order depends on them.
   localparam int unsigned F_SRC_LO = 0;
   localparam int unsigned F_SRC_HI = 1;
   localparam int unsigned F_DST_LO = 2;
   localparam int unsigned F_DST_HI = 3;
   localparam int unsigned F_LNK_LO = 4;
   localparam int unsigned F_LNK_HI = 5;
   localparam int unsigned F_COUNT  = 6;
   localparam int unsigned F_CTRL   = 7;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_XFER  = 2'd2,
      ST_LINK  = 2'd3
   } walk_state_e;
endpackage

// File: rtl/dsc_addr_gen.sv
module dsc_addr_gen #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 8,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              last_o
);
   localparam int unsigned BYTE_SH  = $clog2(DATA_W / 8);
   localparam int unsigned LAST_IDX = NWORDS - 1;

   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load_i) begin
         base_q <= base_i;
         idx_q  <= '0;
      end else if (step_i) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

   assign addr_o = base_q + (ADDR_W'(idx_q) << BYTE_SH);
   assign idx_o  = idx_q;
   assign last_o = (idx_q == IDX_W'(LAST_IDX));
endmodule

// File: rtl/dsc_word_bank.sv
module dsc_word_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 8,
   parameter int unsigned IDX_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_i,
   input  logic [IDX_W-1:0]              idx_i,
   input  logic [DATA_W-1:0]             data_i,
   output logic [NWORDS-1:0][DATA_W-1:0] words_o
);
   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words_o[g] <= '0;
         else if (wr_i && (idx_i == IDX_W'(g)))
            words_o[g] <= data_i;
      end
   end
endmodule

// File: rtl/dsc_walk_seq.sv
module dsc_walk_seq
   import dsc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned ALIGN_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] head_i,
   input  logic              err_clr_i,
   input  logic              mem_ack_i,
   input  logic              mem_err_i,
   input  logic              last_word_i,
   input  logic              count_zero_i,
   input  logic [ADDR_W-1:0] link_i,
   input  logic              xfer_done_i,
   output logic              load_o,
   output logic              use_link_o,
   output logic              wr_o,
   output walk_state_e       state_o,
   output logic              done_o,
   output logic              err_o
);
   walk_state_e st_q, st_d;
   logic        set_err, fin;

   function automatic logic is_aligned(input logic [ADDR_W-1:0] a);
      return (a[ALIGN_BITS-1:0] == '0);
   endfunction

   always_comb begin
      st_d       = st_q;
      load_o     = 1'b0;
      use_link_o = 1'b0;
      wr_o       = 1'b0;
      set_err    = 1'b0;
      fin        = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (head_i == '0) begin
                  fin = 1'b1;
               end else if (!is_aligned(head_i)) begin
                  set_err = 1'b1;
               end else begin
                  load_o = 1'b1;
                  st_d   = ST_FETCH;
               end
            end
         end
         ST_FETCH: begin
            if (mem_ack_i) begin
               if (mem_err_i) begin
                  set_err = 1'b1;
                  st_d    = ST_IDLE;
               end else begin
                  wr_o = 1'b1;
                  if (last_word_i)
                     st_d = count_zero_i ? ST_LINK : ST_XFER;
               end
            end
         end
         ST_XFER: begin
            if (xfer_done_i)
               st_d = ST_LINK;
         end
         ST_LINK: begin
            if (link_i == '0) begin
               fin  = 1'b1;
               st_d = ST_IDLE;
            end else if (!is_aligned(link_i)) begin
               set_err = 1'b1;
               st_d    = ST_IDLE;
            end else begin
               load_o     = 1'b1;
               use_link_o = 1'b1;
               st_d       = ST_FETCH;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_o <= fin;
         if (set_err)
            err_o <= 1'b1;
         else if (err_clr_i)
            err_o <= 1'b0;
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/dsc_chain_walker.sv
module dsc_chain_walker
   import dsc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] head_addr_i,
   input  logic              err_clr_i,
   output logic              busy_o,
   output logic              chain_done_o,
   output logic              err_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_err_i,
   output logic              xfer_req_o,
   output logic [ADDR_W-1:0] xfer_src_o,
   output logic [ADDR_W-1:0] xfer_dst_o,
   output logic [DATA_W-1:0] xfer_len_o,
   output logic [DATA_W-1:0] xfer_ctl_o,
   input  logic              xfer_done_i
);
   localparam int unsigned NWORDS    = DSC_WORDS;
   localparam int unsigned IDX_W     = DSC_IDX_W;
   localparam int unsigned DSC_BYTES = NWORDS * (DATA_W / 8);

   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must be twice DATA_W: pointers are split into two words");
   end
   if (DATA_W != 32) begin : g_bad_data_w
      $error("descriptor words are 32 bits wide");
   end
   if ((1 << ALIGN_BITS) < DSC_BYTES) begin : g_bad_align
      $error("ALIGN_BITS too small to hold one descriptor inside its alignment");
   end

   logic                          load, use_link, wr, last_word;
   logic [IDX_W-1:0]              idx;
   logic [ADDR_W-1:0]             base_sel, link_addr;
   logic [NWORDS-1:0][DATA_W-1:0] words;
   walk_state_e                   st;

   assign link_addr = {words[F_LNK_HI], words[F_LNK_LO]};
   assign base_sel  = use_link ? link_addr : head_addr_i;

   dsc_addr_gen #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .base_i (base_sel),
      .step_i (wr),
      .addr_o (mem_addr_o),
      .idx_o  (idx),
      .last_o (last_word)
   );

   dsc_word_bank #(
      .DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr),
      .idx_i   (idx),
      .data_i  (mem_rdata_i),
      .words_o (words)
   );

   dsc_walk_seq #(
      .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .head_i       (head_addr_i),
      .err_clr_i    (err_clr_i),
      .mem_ack_i    (mem_ack_i),
      .mem_err_i    (mem_err_i),
      .last_word_i  (last_word),
      .count_zero_i (words[F_COUNT] == '0),
      .link_i       (link_addr),
      .xfer_done_i  (xfer_done_i),
      .load_o       (load),
      .use_link_o   (use_link),
      .wr_o         (wr),
      .state_o      (st),
      .done_o       (chain_done_o),
      .err_o        (err_o)
   );

   assign busy_o     = (st != ST_IDLE);
   assign mem_req_o  = (st == ST_FETCH);
   assign xfer_req_o = (st == ST_XFER);
   assign xfer_src_o = {words[F_SRC_HI], words[F_SRC_LO]};
   assign xfer_dst_o = {words[F_DST_HI], words[F_DST_LO]};
   assign xfer_len_o = words[F_COUNT];
   assign xfer_ctl_o = words[F_CTRL];
endmodule

// File: rtl/dsc_chain_walker_chk.sv
module dsc_chain_walker_chk #(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] head_addr_i,
   input logic              err_clr_i,
   input logic              busy_o,
   input logic              chain_done_o,
   input logic              err_o,
   input logic              mem_req_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_ack_i,
   input logic              mem_err_i,
   input logic              xfer_req_o,
   input logic [ADDR_W-1:0] xfer_src_o,
   input logic [ADDR_W-1:0] xfer_dst_o,
   input logic [DATA_W-1:0] xfer_len_o,
   input logic [DATA_W-1:0] xfer_ctl_o,
   input logic              xfer_done_i
);
   localparam int unsigned WBYTES   = DATA_W / 8;
   localparam int unsigned LAST_OFF = (dsc_pkg::DSC_WORDS - 1) * WBYTES;

   a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_ack_i && !mem_err_i
         && (mem_addr_o[ALIGN_BITS-1:0] != ALIGN_BITS'(LAST_OFF))
      |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(WBYTES)));

   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o && !xfer_done_i |=> xfer_req_o);

   a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o && !xfer_done_i |=> $stable(xfer_src_o) && $stable(xfer_dst_o)
         && $stable(xfer_len_o) && $stable(xfer_ctl_o));

   a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req_o && xfer_req_o));

   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done_o |-> !busy_o);

   a_r8_bad_head: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i && (head_addr_i[ALIGN_BITS-1:0] != '0)
      |=> err_o && !busy_o && !mem_req_o);

   a_r9_read_error: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_ack_i && mem_err_i |=> err_o && !busy_o && !chain_done_o);

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !err_clr_i |=> err_o);
endmodule

bind dsc_chain_walker dsc_chain_walker_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .head_addr_i  (head_addr_i),
   .err_clr_i    (err_clr_i),
   .busy_o       (busy_o),
   .chain_done_o (chain_done_o),
   .err_o        (err_o),
   .mem_req_o    (mem_req_o),
   .mem_addr_o   (mem_addr_o),
   .mem_ack_i    (mem_ack_i),
   .mem_err_i    (mem_err_i),
   .xfer_req_o   (xfer_req_o),
   .xfer_src_o   (xfer_src_o),
   .xfer_dst_o   (xfer_dst_o),
   .xfer_len_o   (xfer_len_o),
   .xfer_ctl_o   (xfer_ctl_o),
   .xfer_done_i  (xfer_done_i)
);

// File: tb/tb_dsc_chain_walker.sv
module tb_dsc_chain_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] head_addr_i = '0;
   logic        err_clr_i = 1'b0;
   logic        busy_o, chain_done_o, err_o, mem_req_o, xfer_req_o;
   logic [63:0] mem_addr_o, xfer_src_o, xfer_dst_o;
   logic [31:0] xfer_len_o, xfer_ctl_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_err_i = 1'b0;
   logic        xfer_done_i = 1'b0;

   always #2.5 clk = ~clk;

   dsc_chain_walker dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_addr_i(head_addr_i),
      .err_clr_i(err_clr_i), .busy_o(busy_o), .chain_done_o(chain_done_o),
      .err_o(err_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i),
      .xfer_req_o(xfer_req_o), .xfer_src_o(xfer_src_o), .xfer_dst_o(xfer_dst_o),
      .xfer_len_o(xfer_len_o), .xfer_ctl_o(xfer_ctl_o), .xfer_done_i(xfer_done_i)
   );

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   // memory and stimulus knobs (written by the test thread only)
   logic [31:0] mem [0:255];
   int          exp_base [0:7];
   int          rd_mark = 0;
   int          stall = 0;
   int          xdelay = 0;
   int          err_at = -1;

   // model-owned counters
   int          rd_total = 0;
   int          addr_bad = 0;
   int          xf_total = 0;
   int          stab_bad = 0;
   int          done_total = 0;
   int          scnt = 0;
   int          xcnt = 0;
   logic [63:0] lg_src [0:63];
   logic [63:0] lg_dst [0:63];
   logic [31:0] lg_len [0:63];
   logic [31:0] lg_ctl [0:63];
   logic [63:0] hold_src;

   // memory responder
   always @(negedge clk) begin
      mem_ack_i <= 1'b0;
      mem_err_i <= 1'b0;
      if (rst_n && mem_req_o && !mem_ack_i) begin
         if (scnt < stall) begin
            scnt <= scnt + 1;
         end else begin
            automatic int r = rd_total - rd_mark;
            automatic longint ex = longint'(exp_base[(r / 8) % 8]) + longint'((r % 8) * 4);
            if (mem_addr_o != 64'(ex)) addr_bad <= addr_bad + 1;
            scnt        <= 0;
            mem_ack_i   <= 1'b1;
            mem_rdata_i <= mem[mem_addr_o[9:2]];
            mem_err_i   <= (rd_total == err_at);
            rd_total    <= rd_total + 1;
         end
      end
   end

   // data mover model
   always @(negedge clk) begin
      xfer_done_i <= 1'b0;
      if (chain_done_o) done_total <= done_total + 1;
      if (rst_n && xfer_req_o && !xfer_done_i) begin
         if (xcnt == 0) hold_src <= xfer_src_o;
         else if (hold_src != xfer_src_o) stab_bad <= stab_bad + 1;
         if (xcnt < xdelay) begin
            xcnt <= xcnt + 1;
         end else begin
            xcnt <= 0;
            xfer_done_i <= 1'b1;
            lg_src[xf_total % 64] <= xfer_src_o;
            lg_dst[xf_total % 64] <= xfer_dst_o;
            lg_len[xf_total % 64] <= xfer_len_o;
            lg_ctl[xf_total % 64] <= xfer_ctl_o;
            xf_total <= xf_total + 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int base_of(input int k, input int n, input bit rev);
      return rev ? 64 * (n - k) : 64 * (k + 1);
   endfunction

   function automatic logic [63:0] e_src(input int k, input int seed);
      return {32'hA000_0000 + 32'(seed * 16 + k), 32'h1000_0000 + 32'(k * 256 + seed)};
   endfunction
   function automatic logic [63:0] e_dst(input int k, input int seed);
      return {32'hB000_0000 + 32'(seed + k * 3), 32'h2000_0000 + 32'(k * 128 + seed * 7)};
   endfunction
   function automatic logic [31:0] e_len(input int k, input int seed, input int zmask);
      return zmask[k] ? 32'd0 : 32'((k + 1) * 4 + seed);
   endfunction
   function automatic logic [31:0] e_ctl(input int k, input int seed);
      return 32'hC000_0000 | 32'(k) | 32'(seed << 8);
   endfunction

   task automatic build(input int n, input int seed, input bit rev, input int zmask);
      for (int k = 0; k < n; k++) begin
         automatic int b = base_of(k, n, rev);
         automatic int nx = (k == n - 1) ? 0 : base_of(k + 1, n, rev);
         automatic logic [63:0] s = e_src(k, seed);
         automatic logic [63:0] d = e_dst(k, seed);
         exp_base[k] = b;
         mem[b/4 + 0] = s[31:0];
         mem[b/4 + 1] = s[63:32];
         mem[b/4 + 2] = d[31:0];
         mem[b/4 + 3] = d[63:32];
         mem[b/4 + 4] = 32'(nx);
         mem[b/4 + 5] = 32'h0;
         mem[b/4 + 6] = e_len(k, seed, zmask);
         mem[b/4 + 7] = e_ctl(k, seed);
      end
   endtask

   task automatic launch(input logic [63:0] h, input bit poke);
      rd_mark = rd_total;
      @(negedge clk);
      start_i = 1'b1;
      head_addr_i = h;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         start_i = 1'b1;
         head_addr_i = 64'h300;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int i = 0; i < 4000 && busy_o; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_chain(input int n, input int seed, input bit rev, input int zmask, input bit poke);
      automatic int xf0 = xf_total;
      automatic int dn0 = done_total;
      automatic int ab0 = addr_bad;
      automatic int j = 0;
      automatic int nx = 0;
      build(n, seed, rev, zmask);
      for (int k = 0; k < n; k++) if (!zmask[k]) nx++;
      launch(64'(exp_base[0]), poke);
      check(rd_total - rd_mark == 8 * n, poke ? "R7 read count" : "R2 read count",
            64'(rd_total - rd_mark), 64'(8 * n));
      check(addr_bad == ab0, "R2 read addresses", 64'(addr_bad - ab0), 0);
      check(xf_total - xf0 == nx, "R6 transfer count", 64'(xf_total - xf0), 64'(nx));
      check(done_total - dn0 == 1, "R5 done pulse", 64'(done_total - dn0), 1);
      check(!err_o && !busy_o, "R5 idle without error", {62'b0, err_o, busy_o}, 0);
      for (int k = 0; k < n; k++) begin
         if (!zmask[k] && (xf0 + j < xf_total)) begin
            automatic int ix = (xf0 + j) % 64;
            check(lg_src[ix] == e_src(k, seed), "R3 source", lg_src[ix], e_src(k, seed));
            check(lg_dst[ix] == e_dst(k, seed), "R3 destination", lg_dst[ix], e_dst(k, seed));
            check(lg_len[ix] == e_len(k, seed, zmask), "R3 count", 64'(lg_len[ix]), 64'(e_len(k, seed, zmask)));
            check(lg_ctl[ix] == e_ctl(k, seed), "R3 control", 64'(lg_ctl[ix]), 64'(e_ctl(k, seed)));
            j++;
         end
      end
   endtask

   task automatic clear_err();
      @(negedge clk);
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 0; i < 8; i++) exp_base[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check({busy_o, mem_req_o, xfer_req_o, chain_done_o, err_o} == 5'b0, "R1 reset outputs",
            {59'b0, busy_o, mem_req_o, xfer_req_o, chain_done_o, err_o}, 0);

      // R2 R3 R4 R5: sweep length, ordering, stalls, mover delay
      for (int n = 1; n <= 4; n++)
         for (int st = 0; st <= 2; st++)
            for (int xd = 0; xd <= 2; xd += 2) begin
               stall = st;
               xdelay = xd;
               run_chain(n, n * 10 + st + xd, st[0], 0, 1'b0);
            end
      check(stab_bad == 0, "R4 fields stable during request", 64'(stab_bad), 0);

      // R6: zero counts in various positions
      stall = 1; xdelay = 1;
      run_chain(3, 5, 1'b0, 3'b010, 1'b0);
      run_chain(4, 6, 1'b1, 4'b1001, 1'b0);
      run_chain(3, 7, 1'b0, 3'b111, 1'b0);

      // R7: start while busy is ignored
      stall = 0; xdelay = 3;
      run_chain(3, 9, 1'b0, 0, 1'b1);

      // R11: zero head, no reads, done pulse
      begin
         automatic int dn0 = done_total;
         launch(64'h0, 1'b0);
         check(rd_total == rd_mark, "R11 no reads", 64'(rd_total - rd_mark), 0);
         check(done_total - dn0 == 1, "R11 done pulse", 64'(done_total - dn0), 1);
      end

      // R8: misaligned head
      begin
         automatic int dn0 = done_total;
         launch(64'h44, 1'b0);
         check(err_o, "R8 misaligned head sets error", {63'b0, err_o}, 1);
         check(rd_total == rd_mark, "R8 no reads", 64'(rd_total - rd_mark), 0);
         check(done_total == dn0 && !busy_o, "R8 no done, idle", 64'(done_total - dn0), 0);
         repeat (5) @(negedge clk);
         check(err_o, "R10 error held", {63'b0, err_o}, 1);
         clear_err();
         check(!err_o, "R10 error cleared", {63'b0, err_o}, 0);
      end

      // R8: misaligned link after first descriptor
      begin
         automatic int dn0 = done_total;
         automatic int xf0 = xf_total;
         stall = 0; xdelay = 0;
         build(2, 3, 1'b0, 0);
         mem[exp_base[0]/4 + 4] = 32'h0000_00C4;
         launch(64'(exp_base[0]), 1'b0);
         check(xf_total - xf0 == 1, "R8 one transfer before bad link", 64'(xf_total - xf0), 1);
         check(rd_total - rd_mark == 8, "R8 no reads after bad link", 64'(rd_total - rd_mark), 8);
         check(err_o && done_total == dn0, "R8 link error, no done", {63'b0, err_o}, 1);
         clear_err();
      end

      // R9: read error mid-descriptor
      begin
         automatic int dn0 = done_total;
         automatic int xf0 = xf_total;
         stall = 1;
         build(2, 4, 1'b0, 0);
         err_at = rd_total + 3;
         launch(64'(exp_base[0]), 1'b0);
         err_at = -1;
         check(rd_total - rd_mark == 4, "R9 reads stop at error", 64'(rd_total - rd_mark), 4);
         check(xf_total == xf0, "R9 no transfer", 64'(xf_total - xf0), 0);
         check(err_o && !busy_o && done_total == dn0, "R9 error, idle, no done", {62'b0, err_o, busy_o}, 2);
         clear_err();
         check(!err_o, "R10 cleared after read error", {63'b0, err_o}, 0);
      end

      // recovery after errors
      stall = 2; xdelay = 1;
      run_chain(2, 21, 1'b1, 0, 1'b0);

      summary();
   end
endmodule